// File: doc/BRIEF.md
# Block-Mode DMA Channel

This block is one DMA channel that copies a run of 32-bit words between main memory and a peripheral data port. Software programs three registers through a simple write/read port: a start address, a block-control word and a channel-control word. Writing the control word with its start flag set begins a transfer. The channel accepts only two exact control encodings, one for each direction. Any other start request ends at once, with no data moved.

During a transfer the channel reads or writes memory through a request/grant master port. It moves each word through a valid/ready stream toward or from the peripheral. The address register advances one word per transfer. When the run ends the channel clears its busy flag and raises a single-cycle completion interrupt that carries a fixed channel number.

Top module: `blk_dma_chan`

## Requirements
- R1: The number of words moved equals the upper 16 bits of the block-control register times its lower 16 bits. No extra word is moved.
- R2: Control value 0x01000201 reads memory at ascending word addresses and presents each word on the peripheral output stream in that order. A word offered on the stream is held stable until it is accepted.
- R3: Control value 0x01000200 takes words from the peripheral input stream and writes them to memory at ascending word addresses. Memory past the last word is left unchanged.
- R4: Bit 24 of the control register is the busy flag. At completion it is cleared and every other bit is kept. The register read port selects the address with code 0, block control with code 1 and channel control with code 2.
- R5: After a transfer the address register holds the start address plus four times the word count.
- R6: A start request whose control value is neither supported encoding finishes without any memory or peripheral activity. It raises the interrupt and leaves the address register unchanged.
- R7: A start request whose address is at or above the mapped limit (default 0x200000) behaves as in R6. An address one word below the limit is still mapped.
- R8: Each completion produces exactly one single-cycle interrupt pulse, with the channel number (default 4) on the channel output.
- R9: The two low bits of a written address are stored as zero.
- R10: Writes to any register are ignored while the busy flag is set.
- R11: A start request with a word count of zero completes with an interrupt and moves no data.
- R12: A control write with bit 24 clear stores the value and starts nothing.
- R13: After reset all three registers read zero and no request, stream activity or interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 address, 1 block control, 2 channel control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with the grant |
| per_out_valid | output | 1 | Word offered to the peripheral |
| per_out_ready | input | 1 | Peripheral accepts the offered word |
| per_out_data | output | 32 | Word to the peripheral |
| per_in_valid | input | 1 | Peripheral offers a word |
| per_in_ready | output | 1 | Channel accepts the offered word |
| per_in_data | input | 32 | Word from the peripheral |
| irq_pulse | output | 1 | Completion interrupt, one cycle |
| irq_chan | output | CHAN_W | Channel number of the interrupt |

## Verification
The hardest case to reach from the ports is a register write that arrives while a transfer is stalled mid-run. For that the bench starts an eight-word transfer with the peripheral and memory handshakes throttled by a pseudo-random pattern. It then writes the control and address registers while busy, and checks that the run still ends at the original address with the original control value. The sweep covers every block count and block size from zero to three in both directions, with and without throttling. The zero-count and mapped-limit boundaries are hit directly.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_MRD,
    ST_PUSH,
    ST_PULL,
    ST_MWR,
    ST_DONE
  } seq_state_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_BLK  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam logic [31:0] CMD_TO_PERIPH   = 32'h0100_0201;
  localparam logic [31:0] CMD_FROM_PERIPH = 32'h0100_0200;
  localparam int          BUSY_BIT        = 24;

  typedef struct packed {
    logic ok;
    logic to_periph;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [31:0] v);
    cmd_t c;
    c.ok        = (v == CMD_TO_PERIPH) || (v == CMD_FROM_PERIPH);
    c.to_periph = (v == CMD_TO_PERIPH);
    return c;
  endfunction

endpackage

// File: rtl/dma_len_calc.sv
module dma_len_calc #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] blk_ctrl,
  output logic [2*HALF_W-1:0] word_cnt
);
  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] n_blocks;
  logic [FULL_W-1:0] blk_size;

  assign n_blocks = FULL_W'(blk_ctrl[FULL_W-1:HALF_W]);
  assign blk_size = FULL_W'(blk_ctrl[HALF_W-1:0]);
  assign word_cnt = n_blocks * blk_size;

endmodule

// File: rtl/dma_word_buf.sv
module dma_word_buf #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_mem,
  input  logic [W-1:0] mem_data,
  input  logic         load_per,
  input  logic [W-1:0] per_data,
  output logic [W-1:0] q
);
  logic [W-1:0] buf_d;
  logic         buf_en;

  always_comb begin
    buf_en = load_mem | load_per;
    buf_d  = load_mem ? mem_data : per_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (buf_en) q <= buf_d;
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmd_ok,
  input  logic             to_periph,
  input  logic             mapped,
  input  logic [CNT_W-1:0] word_cnt,
  input  logic             mem_gnt,
  input  logic             per_out_ready,
  input  logic             per_in_valid,
  output logic             mem_req,
  output logic             mem_we,
  output logic             per_out_valid,
  output logic             per_in_ready,
  output logic             cap_mem,
  output logic             cap_per,
  output logic             word_done,
  output logic             finish
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             remain_en;

  always_comb begin
    state_d       = state_q;
    remain_d      = remain_q;
    remain_en     = 1'b0;
    mem_req       = 1'b0;
    mem_we        = 1'b0;
    per_out_valid = 1'b0;
    per_in_ready  = 1'b0;
    cap_mem       = 1'b0;
    cap_per       = 1'b0;
    word_done     = 1'b0;
    finish        = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_SETUP;
      ST_SETUP: begin
        remain_d  = word_cnt;
        remain_en = 1'b1;
        if (!cmd_ok || !mapped || (word_cnt == '0)) state_d = ST_DONE;
        else if (to_periph)                          state_d = ST_MRD;
        else                                         state_d = ST_PULL;
      end
      ST_MRD: begin
        mem_req = 1'b1;
        if (mem_gnt) begin
          cap_mem = 1'b1;
          state_d = ST_PUSH;
        end
      end
      ST_PUSH: begin
        per_out_valid = 1'b1;
        if (per_out_ready) begin
          word_done = 1'b1;
          remain_d  = remain_q - ONE;
          remain_en = 1'b1;
          state_d   = (remain_q == ONE) ? ST_DONE : ST_MRD;
        end
      end
      ST_PULL: begin
        per_in_ready = 1'b1;
        if (per_in_valid) begin
          cap_per = 1'b1;
          state_d = ST_MWR;
        end
      end
      ST_MWR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_gnt) begin
          word_done = 1'b1;
          remain_d  = remain_q - ONE;
          remain_en = 1'b1;
          state_d   = (remain_q == ONE) ? ST_DONE : ST_PULL;
        end
      end
      ST_DONE: begin
        finish  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
    end else begin
      state_q <= state_d;
      if (remain_en) remain_q <= remain_d;
    end
  end

  AST_BAD_CMD_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && !cmd_ok) |=> (state_q == ST_DONE)); // R6
  AST_UNMAPPED_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && !mapped) |=> (state_q == ST_DONE)); // R7
  AST_ZERO_CNT_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && word_cnt == '0) |=> (state_q == ST_DONE)); // R11
  AST_NO_EXTRA_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (remain_q != '0)); // R1

endmodule

// File: rtl/blk_dma_chan.sv
module blk_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int              ADDR_W  = 24,
  parameter logic [ADDR_W-1:0] MAP_TOP = 24'h20_0000,
  parameter int              CHAN_W  = 3,
  parameter int              CHAN_ID = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  output logic              per_out_valid,
  input  logic              per_out_ready,
  output logic [31:0]       per_out_data,
  input  logic              per_in_valid,
  output logic              per_in_ready,
  input  logic [31:0]       per_in_data,
  output logic              irq_pulse,
  output logic [CHAN_W-1:0] irq_chan
);
  localparam int                HALF_W = 16;
  localparam int                WORD_W = 2 * HALF_W;
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(4);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] blk_q;
  logic [WORD_W-1:0] ctrl_q, ctrl_d;
  logic              addr_en, blk_en, ctrl_en;
  logic              busy, wr_ok, start;
  logic              mapped;
  cmd_t              cmd;
  logic [WORD_W-1:0] word_cnt;
  logic              cap_mem, cap_per, word_done, finish;
  logic [WORD_W-1:0] buf_q;

  assign busy   = ctrl_q[BUSY_BIT];
  assign wr_ok  = reg_we && !busy;
  assign start  = wr_ok && (reg_sel == SEL_CTRL) && reg_wdata[BUSY_BIT];
  assign cmd    = decode_cmd(ctrl_q);
  assign mapped = (addr_q < MAP_TOP);

  always_comb begin
    addr_en = 1'b0;
    addr_d  = addr_q;
    if (wr_ok && reg_sel == SEL_ADDR) begin
      addr_en = 1'b1;
      addr_d  = {reg_wdata[ADDR_W-1:2], 2'b00};
    end else if (word_done) begin
      addr_en = 1'b1;
      addr_d  = addr_q + STEP;
    end
    blk_en  = wr_ok && (reg_sel == SEL_BLK);
    ctrl_en = 1'b0;
    ctrl_d  = ctrl_q;
    if (wr_ok && reg_sel == SEL_CTRL) begin
      ctrl_en = 1'b1;
      ctrl_d  = reg_wdata;
    end else if (finish) begin
      ctrl_en          = 1'b1;
      ctrl_d[BUSY_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      blk_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (blk_en)  blk_q  <= reg_wdata;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_ADDR: reg_rdata = WORD_W'(addr_q);
      SEL_BLK:  reg_rdata = blk_q;
      SEL_CTRL: reg_rdata = ctrl_q;
      default:  reg_rdata = '0;
    endcase
  end

  dma_len_calc #(.HALF_W(HALF_W)) u_len (
    .blk_ctrl (blk_q),
    .word_cnt (word_cnt)
  );

  dma_seq #(.CNT_W(WORD_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cmd_ok        (cmd.ok),
    .to_periph     (cmd.to_periph),
    .mapped        (mapped),
    .word_cnt      (word_cnt),
    .mem_gnt       (mem_gnt),
    .per_out_ready (per_out_ready),
    .per_in_valid  (per_in_valid),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .per_out_valid (per_out_valid),
    .per_in_ready  (per_in_ready),
    .cap_mem       (cap_mem),
    .cap_per       (cap_per),
    .word_done     (word_done),
    .finish        (finish)
  );

  dma_word_buf #(.W(WORD_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_mem (cap_mem),
    .mem_data (mem_rdata),
    .load_per (cap_per),
    .per_data (per_in_data),
    .q        (buf_q)
  );

  assign mem_addr     = addr_q;
  assign mem_wdata    = buf_q;
  assign per_out_data = buf_q;
  assign irq_pulse    = finish;
  assign irq_chan     = CHAN_W'(CHAN_ID);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (addr_q == $past(addr_q) + STEP)); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R8
  AST_IRQ_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !ctrl_q[BUSY_BIT]); // R4
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CTRL && busy && !irq_pulse) |=> ctrl_q[BUSY_BIT]); // R10
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (per_out_valid && !per_out_ready) |=> (per_out_valid && $stable(per_out_data))); // R2
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_out_valid && per_in_ready)); // R2

endmodule

// File: tb/blk_dma_chan_bench.sv
module blk_dma_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        per_out_valid, per_out_ready;
  logic [31:0] per_out_data;
  logic        per_in_valid, per_in_ready;
  logic [31:0] per_in_data;
  logic        irq_pulse;
  logic [2:0]  irq_chan;

  int tests = 0;
  int fails = 0;
  bit reported = 0;
  logic stall_on = 1'b0;
  logic clr_cnt = 1'b0;
  logic [7:0] lfsr;
  logic [31:0] mem [0:511];
  logic [31:0] sink_buf [0:15];
  int sink_n, src_n, irq_n, bad_chan;

  always #4 clk = ~clk;

  blk_dma_chan u_blk_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .per_out_valid(per_out_valid),
    .per_out_ready(per_out_ready), .per_out_data(per_out_data),
    .per_in_valid(per_in_valid), .per_in_ready(per_in_ready),
    .per_in_data(per_in_data), .irq_pulse(irq_pulse), .irq_chan(irq_chan)
  );

  always @(negedge clk or negedge rst_n)
    if (!rst_n) lfsr <= 8'h5A;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  assign mem_gnt       = mem_req && (!stall_on || lfsr[0]);
  assign per_out_ready = !stall_on || lfsr[1];
  assign per_in_valid  = !stall_on || lfsr[2];
  assign per_in_data   = 32'hA500_0000 + src_n;
  assign mem_rdata     = mem[mem_addr[10:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= 32'h1000_0000 + i;
    end else if (mem_req && mem_gnt && mem_we) begin
      mem[mem_addr[10:2]] <= mem_wdata;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr_cnt) begin
      sink_n <= 0; src_n <= 0; irq_n <= 0; bad_chan <= 0;
    end else begin
      if (per_out_valid && per_out_ready) begin
        if (sink_n < 16) sink_buf[sink_n] <= per_out_data;
        sink_n <= sink_n + 1;
      end
      if (per_in_valid && per_in_ready) src_n <= src_n + 1;
      if (irq_pulse) begin
        irq_n <= irq_n + 1;
        if (irq_chan != 3'd4) bad_chan <= bad_chan + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk); reg_sel = sel; #1 v = reg_rdata;
  endtask

  task automatic clear();
    @(negedge clk); clr_cnt = 1'b1;
    @(negedge clk); clr_cnt = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000 && irq_n == 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_m2p(input int base, input int nb, input int bs);
    logic [31:0] v;
    int n = nb * bs;
    clear();
    wr(2'd0, base); wr(2'd1, {16'(nb), 16'(bs)}); wr(2'd2, 32'h0100_0201);
    wait_irq();
    chk(sink_n == n, n == 0 ? "R11" : "R1", "words sent", sink_n, n);
    for (int i = 0; i < n; i++)
      chk(sink_buf[i] == 32'h1000_0000 + base / 4 + i, "R2", "word order",
          sink_buf[i], 32'h1000_0000 + base / 4 + i);
    rd(2'd0, v); chk(v == base + 4 * n, "R5", "end address", v, base + 4 * n);
    rd(2'd2, v); chk(v == 32'h0000_0201, "R4", "busy cleared", v, 32'h0000_0201);
    chk(irq_n == 1 && bad_chan == 0, "R8", "one irq on channel 4", irq_n, 1);
  endtask

  task automatic run_p2m(input int base, input int nb, input int bs);
    logic [31:0] v;
    int n = nb * bs;
    int w = base / 4;
    clear();
    wr(2'd0, base); wr(2'd1, {16'(nb), 16'(bs)}); wr(2'd2, 32'h0100_0200);
    wait_irq();
    chk(src_n == n, n == 0 ? "R11" : "R1", "words taken", src_n, n);
    for (int i = 0; i < n; i++)
      chk(mem[w + i] == 32'hA500_0000 + i, "R3", "stored word", mem[w + i],
          32'hA500_0000 + i);
    chk(mem[w + n] == 32'h1000_0000 + w + n, "R3", "word past end untouched",
        mem[w + n], 32'h1000_0000 + w + n);
    rd(2'd0, v); chk(v == base + 4 * n, "R5", "end address", v, base + 4 * n);
    rd(2'd2, v); chk(v == 32'h0000_0200, "R4", "busy cleared", v, 32'h0000_0200);
    chk(irq_n == 1 && bad_chan == 0, "R8", "one irq on channel 4", irq_n, 1);
  endtask

  task automatic run_skip(input int base, input logic [31:0] cmd, input string req);
    logic [31:0] v;
    clear();
    wr(2'd0, base); wr(2'd1, 32'h0002_0002); wr(2'd2, cmd);
    wait_irq();
    chk(sink_n == 0 && src_n == 0, req, "no data moved", sink_n + src_n, 0);
    rd(2'd0, v); chk(v == base, req, "address unchanged", v, base);
    rd(2'd2, v); chk(v == (cmd & ~32'h0100_0000), req, "busy cleared", v,
                     cmd & ~32'h0100_0000);
    chk(irq_n == 1, req, "irq raised", irq_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    for (int s = 0; s < 3; s++) begin
      rd(2'(s), v); chk(v == 0, "R13", "register after reset", v, 0);
    end
    chk(!mem_req && !per_out_valid && !per_in_ready && !irq_pulse, "R13",
        "idle outputs", {mem_req, per_out_valid, per_in_ready, irq_pulse}, 0);

    // R9 address alignment
    wr(2'd0, 32'h0000_0043); rd(2'd0, v);
    chk(v == 32'h40, "R9", "aligned address", v, 32'h40);

    // R12 control write without start
    clear();
    wr(2'd2, 32'h0000_0201);
    repeat (6) @(negedge clk);
    chk(irq_n == 0 && sink_n == 0, "R12", "no start", irq_n + sink_n, 0);
    rd(2'd2, v); chk(v == 32'h0000_0201, "R12", "stored value", v, 32'h201);

    // R1 R2 R5 R11 sweep, memory to peripheral
    for (int k = 0; k < 32; k++) begin
      stall_on = k[4];
      run_m2p((k % 16) * 48, (k % 16) / 4, k % 4);
    end
    // R1 R3 sweep, peripheral to memory
    for (int k = 0; k < 32; k++) begin
      stall_on = k[4];
      run_p2m(32'h400 + (k % 16) * 48, (k % 16) / 4, k % 4);
    end

    // R6 unsupported encodings
    stall_on = 1'b0;
    run_skip(32'h40, 32'h0100_0202, "R6");
    run_skip(32'h40, 32'h1100_0201, "R6");
    // R7 unmapped start, and the last mapped word
    run_skip(32'h20_0000, 32'h0100_0201, "R7");
    clear();
    wr(2'd0, 32'h1F_FFFC); wr(2'd1, 32'h0001_0001); wr(2'd2, 32'h0100_0201);
    wait_irq();
    chk(sink_n == 1, "R7", "last mapped word moved", sink_n, 1);

    // R10 writes while busy are ignored
    stall_on = 1'b1;
    clear();
    wr(2'd0, 32'h80); wr(2'd1, 32'h0001_0008); wr(2'd2, 32'h0100_0201);
    wr(2'd2, 32'h0000_0000);
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, 32'h0000_0000);
    wait_irq();
    chk(sink_n == 8, "R10", "words sent", sink_n, 8);
    rd(2'd0, v); chk(v == 32'hA0, "R10", "address after busy writes", v, 32'hA0);
    rd(2'd2, v); chk(v == 32'h0000_0201, "R10", "control kept", v, 32'h201);
    rd(2'd1, v); chk(v == 32'h0001_0008, "R10", "block control kept", v, 32'h0001_0008);

    report();
  end

endmodule